// File: doc/BRIEF.md
# Masked UART Interrupt Controller

This block gathers four status sources of a serial UART into one active-low interrupt request. Each source has its own enable bit. The four sources are as follows:

- A latched transmit-buffer-empty event.
- A receive-data-available level.
- The parity bit of the oldest word waiting in the receive FIFO.
- A dual-purpose fault bit. While the UART is in shutdown, it records any activity on the receive line. In normal operation, it records a framing error on the most recent character.

A host reaches the UART through 16-bit serial frames. The serial shifter raises a one-cycle pulse on the 16th rising clock edge of each data read or data write frame. That pulse acknowledges the latched transmit-empty event. The block also builds the 16-bit status and data word that the shifter returns during a data read. Everything is synchronous to one clock with an active-high synchronous reset. Both outputs are registered.

Top module: `uart_irq_ctrl`

## Requirements
- R1: `irq_n` is registered and is low one clock after any source whose enable bit is 1 is set. It is high one clock after no enabled source is set.
- R2: The transmit-empty source is set on the clock that sees `txbuf_empty` rise from 0 to 1. It stays set while `txbuf_empty` remains high.
- R3: A high `access_done` clears the transmit-empty source. If a rising `txbuf_empty` arrives on the same clock as `access_done`, the source stays set.
- R4: The data-available source follows `rx_avail` as a level, with no latching.
- R5: The parity source is 1 only when `par_en`, `fifo_par_bit` and `rx_avail` are all 1. Otherwise it is 0.
- R6: While `shutdown` is high, the fault bit sets on any change of `rx_line`. The fault bit clears on the clock that sees `shutdown` change in either direction.
- R7: While `shutdown` is low, a `frame_done` pulse loads the fault bit with `frame_bad`: 1 for a zero stop bit, 0 for a well-framed character. In shutdown, `frame_done` has no effect on the fault bit.
- R8: `rdback` is registered one clock after its inputs. Its layout, by bit position, is:
  - bit 15: `rx_avail`
  - bit 14: `txbuf_empty`
  - bits 13 to 11: zero
  - bit 10: the fault bit
  - bit 9: the inverse of `cts_n`
  - bit 8: the parity source
  - bits 7 to 0: `rx_data`
- R9: `cfg_wr` loads `cfg_mask` into the enable register, so `irq_n` follows the new enables one clock after the load. The enable bit positions are:
  - bit 0: transmit-empty
  - bit 1: data-available
  - bit 2: parity
  - bit 3: fault

  Reset clears all enables and all latched sources, and drives `irq_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load strobe for the enable bits |
| cfg_mask | input | 4 | New enable bits |
| txbuf_empty | input | 1 | Transmit buffer empty level |
| access_done | input | 1 | Pulse on the 16th clock edge of a data frame |
| rx_avail | input | 1 | Unread receive data present |
| par_en | input | 1 | Parity checking enabled |
| fifo_par_bit | input | 1 | Parity bit of the oldest FIFO entry |
| shutdown | input | 1 | UART in shutdown |
| rx_line | input | 1 | Receive line level |
| frame_done | input | 1 | Character reception finished |
| frame_bad | input | 1 | Stop bit sampled as zero (with frame_done) |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rx_data | input | 8 | Oldest received data byte |
| irq_n | output | 1 | Interrupt request, active low |
| rdback | output | 16 | Status and data readback word |

## Verification
The bench builds the block with its default widths: an 8-bit data field inside a 16-bit word, which leaves three zero pad bits. With these defaults, every bit of the readback word can be compared against a fixed 16-bit constant. A vector table covers each enable bit on its own and the parity gating. Directed runs cover the following:
- the set-over-clear race on the transmit-empty source
- the one-clock latency of an enable load
- the fault bit being cleared when shutdown is entered and again when it is left

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC    = 4;
  localparam int SRC_TXE = 0;
  localparam int SRC_RXA = 1;
  localparam int SRC_PAR = 2;
  localparam int SRC_FLT = 3;
endpackage

// File: rtl/uirq_txe_latch.sv
module uirq_txe_latch (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic clr,
  output logic flag
);
  logic prev;
  logic rise;

  assign rise = lvl & ~prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= 1'b0;
      flag <= 1'b0;
    end else begin
      prev <= lvl;
      // a new empty event outranks the acknowledge
      if (rise)
        flag <= 1'b1;
      else if (clr)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/uirq_fault_track.sv
module uirq_fault_track (
  input  logic clk,
  input  logic rst,
  input  logic shutdown,
  input  logic rx_line,
  input  logic frame_done,
  input  logic frame_bad,
  output logic flt
);
  logic shdn_prev;
  logic rx_prev;
  logic mode_edge;
  logic line_edge;

  assign mode_edge = shutdown ^ shdn_prev;
  assign line_edge = rx_line ^ rx_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shdn_prev <= 1'b0;
      rx_prev   <= 1'b1;
      flt       <= 1'b0;
    end else begin
      shdn_prev <= shutdown;
      rx_prev   <= rx_line;
      if (mode_edge)
        flt <= 1'b0;
      else if (shutdown) begin
        if (line_edge)
          flt <= 1'b1;
      end else if (frame_done)
        flt <= frame_bad;
    end
  end
endmodule

// File: rtl/uirq_word_pack.sv
module uirq_word_pack #(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxa,
  input  logic              txe_lvl,
  input  logic              flt,
  input  logic              cts_n,
  input  logic              par,
  input  logic [DATA_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - DATA_W - 5;

  always_ff @(posedge clk) begin
    if (rst)
      word <= '0;
    else
      word <= {rxa, txe_lvl, {PAD_W{1'b0}}, flt, ~cts_n, par, data};
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uirq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [NSRC-1:0]   cfg_mask,
  input  logic              txbuf_empty,
  input  logic              access_done,
  input  logic              rx_avail,
  input  logic              par_en,
  input  logic              fifo_par_bit,
  input  logic              shutdown,
  input  logic              rx_line,
  input  logic              frame_done,
  input  logic              frame_bad,
  input  logic              cts_n,
  input  logic [DATA_W-1:0] rx_data,
  output logic              irq_n,
  output logic [WORD_W-1:0] rdback
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] src;
  logic [NSRC-1:0] gated;
  logic            txe_flag;
  logic            flt_q;
  logic            par_src;

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else if (cfg_wr)
      mask_q <= cfg_mask;
  end

  uirq_txe_latch u_txe (
    .clk (clk),
    .rst (rst),
    .lvl (txbuf_empty),
    .clr (access_done),
    .flag(txe_flag)
  );

  uirq_fault_track u_flt (
    .clk       (clk),
    .rst       (rst),
    .shutdown  (shutdown),
    .rx_line   (rx_line),
    .frame_done(frame_done),
    .frame_bad (frame_bad),
    .flt       (flt_q)
  );

  assign par_src = par_en & fifo_par_bit & rx_avail;

  always_comb begin
    src          = '0;
    src[SRC_TXE] = txe_flag;
    src[SRC_RXA] = rx_avail;
    src[SRC_PAR] = par_src;
    src[SRC_FLT] = flt_q;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = src[i] & mask_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_n <= 1'b1;
    else
      irq_n <= ~(|gated);
  end

  uirq_word_pack #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .rxa    (rx_avail),
    .txe_lvl(txbuf_empty),
    .flt    (flt_q),
    .cts_n  (cts_n),
    .par    (par_src),
    .data   (rx_data),
    .word   (rdback)
  );
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              txbuf_empty,
  input logic              access_done,
  input logic              rx_avail,
  input logic              shutdown,
  input logic              cts_n,
  input logic              irq_n,
  input logic [WORD_W-1:0] rdback,
  input logic [3:0]        mask_q,
  input logic              txe_flag,
  input logic              flt_q
);
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (mask_q == 4'b0) |=> irq_n); // R1
  AST_TXE_SET: assert property (@(posedge clk) disable iff (rst)
    $rose(txbuf_empty) |=> txe_flag); // R2
  AST_TXE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (access_done && !$rose(txbuf_empty)) |=> !txe_flag); // R3
  AST_RXA_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (rx_avail && mask_q[1]) |=> !irq_n); // R4
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && shutdown != $past(shutdown)) |=> !flt_q); // R6
  AST_CTS_BIT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |=> rdback[9] == !$past(cts_n)); // R8
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .txbuf_empty(txbuf_empty),
  .access_done(access_done),
  .rx_avail   (rx_avail),
  .shutdown   (shutdown),
  .cts_n      (cts_n),
  .irq_n      (irq_n),
  .rdback     (rdback),
  .mask_q     (mask_q),
  .txe_flag   (txe_flag),
  .flt_q      (flt_q)
);

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/1ps
module uart_irq_ctrl_test;
  logic clk = 1'b0;
  logic rst;
  logic cfg_wr, txbuf_empty, access_done, rx_avail, par_en, fifo_par_bit;
  logic shutdown, rx_line, frame_done, frame_bad, cts_n;
  logic [3:0]  cfg_mask;
  logic [7:0]  rx_data;
  logic        irq_n;
  logic [15:0] rdback;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ctrl uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mask(cfg_mask),
    .txbuf_empty(txbuf_empty), .access_done(access_done), .rx_avail(rx_avail),
    .par_en(par_en), .fifo_par_bit(fifo_par_bit), .shutdown(shutdown),
    .rx_line(rx_line), .frame_done(frame_done), .frame_bad(frame_bad),
    .cts_n(cts_n), .rx_data(rx_data), .irq_n(irq_n), .rdback(rdback)
  );

  // [32:29] mask [28] avail [27] par_en [26] par_bit [25] cts_n
  // [24:17] data [16] expected irq_n [15:0] expected rdback
  localparam logic [32:0] VEC [6] = '{
    {4'b0010, 1'b1, 1'b0, 1'b0, 1'b1, 8'hA5, 1'b0, 16'h80A5},
    {4'b0001, 1'b1, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 16'h803C},
    {4'b0100, 1'b1, 1'b1, 1'b1, 1'b0, 8'h55, 1'b0, 16'h8355},
    {4'b0100, 1'b1, 1'b0, 1'b1, 1'b0, 8'h55, 1'b1, 16'h8255},
    {4'b1011, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 1'b1, 16'h0000},
    {4'b1111, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 16'h00FF}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_mask(input logic [3:0] m);
    cfg_mask = m;
    cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 1'b0; cfg_mask = 4'b0; txbuf_empty = 1'b0;
    access_done = 1'b0; rx_avail = 1'b0; par_en = 1'b0; fifo_par_bit = 1'b0;
    shutdown = 1'b0; rx_line = 1'b1; frame_done = 1'b0; frame_bad = 1'b0;
    cts_n = 1'b1; rx_data = 8'h00;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R9 reset irq_n", {31'b0, irq_n}, 32'd1);
    chk("R9 reset rdback", {16'b0, rdback}, 32'h0);

    // table walk: R1 R4 R5 R8
    for (int i = 0; i < 6; i++) begin
      cfg_mask = VEC[i][32:29];
      cfg_wr = 1'b1;
      rx_avail = VEC[i][28];
      par_en = VEC[i][27];
      fifo_par_bit = VEC[i][26];
      cts_n = VEC[i][25];
      rx_data = VEC[i][24:17];
      tick(1);
      cfg_wr = 1'b0;
      tick(2);
      chk($sformatf("R1 R4 R5 vec%0d irq_n", i), {31'b0, irq_n}, {31'b0, VEC[i][16]});
      chk($sformatf("R8 vec%0d rdback", i), {16'b0, rdback}, {16'b0, VEC[i][15:0]});
    end

    // R9: new enables act one clock after the load
    rx_avail = 1'b1; rx_data = 8'h00; par_en = 1'b0; cts_n = 1'b1;
    load_mask(4'b0000);
    tick(2);
    chk("R9 all masked irq_n", {31'b0, irq_n}, 32'd1);
    cfg_mask = 4'b0010; cfg_wr = 1'b1;
    tick(1);
    cfg_wr = 1'b0;
    chk("R9 load edge irq_n unchanged", {31'b0, irq_n}, 32'd1);
    tick(1);
    chk("R9 irq_n after load", {31'b0, irq_n}, 32'd0);
    rx_avail = 1'b0;
    tick(2);
    chk("R4 level drop irq_n", {31'b0, irq_n}, 32'd1);

    // R2 / R3 transmit-empty source
    load_mask(4'b0001);
    txbuf_empty = 1'b1;
    tick(2);
    chk("R2 txe set irq_n", {31'b0, irq_n}, 32'd0);
    chk("R8 txe rdback", {16'b0, rdback}, 32'h4000);
    tick(3);
    chk("R2 txe held irq_n", {31'b0, irq_n}, 32'd0);
    access_done = 1'b1;
    tick(1);
    access_done = 1'b0;
    tick(1);
    chk("R3 access clears irq_n", {31'b0, irq_n}, 32'd1);
    txbuf_empty = 1'b0;
    tick(1);
    txbuf_empty = 1'b1; access_done = 1'b1;
    tick(1);
    access_done = 1'b0;
    tick(1);
    chk("R3 set wins over clear irq_n", {31'b0, irq_n}, 32'd0);
    access_done = 1'b1;
    tick(1);
    access_done = 1'b0; txbuf_empty = 1'b0;
    tick(2);

    // R7 framing error in normal mode
    load_mask(4'b1000);
    frame_done = 1'b1; frame_bad = 1'b1;
    tick(1);
    frame_done = 1'b0;
    tick(1);
    chk("R7 framing set irq_n", {31'b0, irq_n}, 32'd0);
    chk("R7 framing rdback", {16'b0, rdback}, 32'h0400);
    frame_done = 1'b1; frame_bad = 1'b0;
    tick(1);
    frame_done = 1'b0;
    tick(1);
    chk("R7 good frame clears irq_n", {31'b0, irq_n}, 32'd1);
    frame_done = 1'b1; frame_bad = 1'b1;
    tick(1);
    frame_done = 1'b0;
    tick(1);

    // R6 activity in shutdown
    shutdown = 1'b1;
    tick(2);
    chk("R6 entry clears rdback", {16'b0, rdback}, 32'h0);
    chk("R6 entry clears irq_n", {31'b0, irq_n}, 32'd1);
    rx_line = 1'b0;
    tick(2);
    chk("R6 activity sets irq_n", {31'b0, irq_n}, 32'd0);
    chk("R6 activity rdback", {16'b0, rdback}, 32'h0400);
    frame_done = 1'b1; frame_bad = 1'b0;
    tick(1);
    frame_done = 1'b0;
    tick(1);
    chk("R7 frame ignored in shutdown", {16'b0, rdback}, 32'h0400);
    shutdown = 1'b0;
    tick(2);
    chk("R6 exit clears rdback", {16'b0, rdback}, 32'h0);
    chk("R6 exit clears irq_n", {31'b0, irq_n}, 32'd1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule